// File: doc/BRIEF.md
# Randomized Double-Base Scalar Recoder

This block keeps a scalar as a short list of signed terms of the form ±2^a·3^b and rewrites that list one step at a time, always preserving its integer value. A step is either an expansion, which splits one term into two smaller terms, or a reduction, which merges two terms into one. Which term is touched and which identity is used come from an internal pseudo-random sequence. As a result, two scalar multiplications with the same scalar can walk through different doubling and tripling schedules. The surrounding controller decides how many expansions and reductions to issue, and in what order.

Three identities drive the rewriting: 3 = 1 + 2, 4 = 1 + 3 and 9 = 1 + 8, each usable in either direction. A load port replaces the whole list with a single term. Every request completes in one cycle and reports whether it changed the list. The list can hold up to N terms. Exponents are limited to the widths of their fields, so a rewrite whose result would not fit is treated as not applicable.

Top module: `dbr_recoder`

## Requirements
- R1: After reset the term count is 0, every slot holds sign 0 and exponents 0, and `done` and `noOp` are low.
- R2: When `loadReq` is high at a clock edge, the list becomes the single term (`loadSign`, `loadA`, `loadB`) in slot 0, the count becomes 1 and every other slot is cleared. A load takes priority over an `opReq` in the same cycle: that request is dropped, and no `done` follows it.
- R3: The integer value of the list, the sum over valid slots of (−1 if sign is 1, else +1)·2^a·3^b, is never changed by an expansion or a reduction.
- R4: A 16-bit LFSR with seed 0xACE1 shifts left and takes in bit15^bit13^bit12^bit10. It advances exactly once for each accepted request, where an accepted request is `opReq` without `loadReq`. The advanced value picks the anchor slot as bits[7:0] modulo count and the first rule as bits[11:8] modulo 3. Rules are then tried in the order start, start+1 and start+2, modulo 3, where rule 0 is 3=1+2, rule 1 is 4=1+3 and rule 2 is 9=1+8.
- R5: An expansion (`opMode`=0) of anchor (s,a,b) uses the first applicable rule. Rule 0 needs b≥1 and gives (s,a,b−1) plus (s,a+1,b−1). Rule 1 needs a≥2 and gives (s,a−2,b) plus (s,a−2,b+1). Rule 2 needs b≥2 and gives (s,a,b−2) plus (s,a+3,b−2). The first part replaces the anchor, the second is placed at slot index count, and the count grows by 1.
- R6: A reduction (`opMode`=1) treats the anchor (s,a,b) as the smaller part. For each rule in order, it searches for the lowest-index other valid slot of the same sign that matches exactly: (a+1,b) for rule 0, (a,b+1) for rule 1, (a+3,b) for rule 2. The anchor becomes (s,a,b+1), (s,a+2,b) or (s,a,b+2) respectively. The partner is removed, later slots shift down by one, and the count drops by 1.
- R7: An expansion with count 0 or count N, a reduction with count below 2, or a request where no rule applies leaves the list unchanged and raises `noOp` together with `done`.
- R8: A rule whose result needs a larger exponent than the field can hold (a > 2^AW−1 or b > 2^BW−1) is treated as not applicable.
- R9: `done` is high for exactly the one cycle after each accepted request and is low otherwise.
- R10: The count never exceeds N, and every slot at or above the count reads as all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loadReq | input | 1 | Replace the list with one term |
| loadSign | input | 1 | Sign of loaded term (1 = negative) |
| loadA | input | AW | Power-of-two exponent of loaded term |
| loadB | input | BW | Power-of-three exponent of loaded term |
| opReq | input | 1 | Request one rewrite step |
| opMode | input | 1 | 0 = expansion, 1 = reduction |
| termSignVec | output | N | Sign of each slot, slot i at bit i |
| termAVec | output | N*AW | Power-of-two exponents, slot i at [i*AW +: AW] |
| termBVec | output | N*BW | Power-of-three exponents, slot i at [i*BW +: BW] |
| termCount | output | $clog2(N+1) | Number of valid slots |
| done | output | 1 | One-cycle pulse after an accepted request |
| noOp | output | 1 | With done: the request changed nothing |

## Verification
A corrupted slot or a wrong shift after a merge changes the rebuilt integer value, and that shows on the term outputs in the very cycle after the faulty step. An LFSR that drifts from its sequence, or a wrong anchor or rule choice, leaves the value intact. It does, however, put the list into a different arrangement that can be told apart at the next edge, because the bench's behavioural model predicts every slot cycle by cycle. A count that is off by one shows up either as a nonzero slot above the count or as a missing term, again one cycle after the step.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam int IDXW = 8;

  typedef enum logic [1:0] {
    RULE_THREE = 2'd0,
    RULE_FOUR  = 2'd1,
    RULE_NINE  = 2'd2
  } rule_e;

  typedef struct packed {
    logic            load;
    logic            split;
    logic            merge;
    rule_e           rule;
    logic [IDXW-1:0] anchor;
    logic [IDXW-1:0] partner;
  } strobe_t;
endpackage

// File: rtl/dbr_ctrl.sv
module dbr_ctrl
  import dbr_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 4,
  parameter int BW = 3,
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          loadReq,
  input  logic          opReq,
  input  logic          opMode,
  input  logic          termSign [N],
  input  logic [AW-1:0] termA    [N],
  input  logic [BW-1:0] termB    [N],
  input  logic [CW-1:0] termCount,
  output strobe_t       strobe,
  output logic          done,
  output logic          noOp
);
  localparam int MAXA = (1 << AW) - 1;
  localparam int MAXB = (1 << BW) - 1;
  localparam logic [15:0] SEED = 16'hACE1;

  logic [15:0] lfsr, lfsrNext;
  logic opGo, doSplit, doMerge, splitHit, mergeHit;
  int cnt, anchorI, ruleStart, splitRule, mergeRule, partnerI;
  int rr, aI, bI;

  function automatic bit splitFits(int r, int a, int b);
    case (r)
      0:       return (b >= 1) && (a + 1 <= MAXA);
      1:       return (a >= 2) && (b + 1 <= MAXB);
      default: return (b >= 2) && (a + 3 <= MAXA);
    endcase
  endfunction

  function automatic bit mergeFits(int r, int a, int b, int a2, int b2);
    case (r)
      0:       return (a2 == a + 1) && (b2 == b) && (b + 1 <= MAXB);
      1:       return (a2 == a) && (b2 == b + 1) && (a + 2 <= MAXA);
      default: return (a2 == a + 3) && (b2 == b) && (b + 2 <= MAXB);
    endcase
  endfunction

  assign opGo     = opReq && !loadReq;
  assign lfsrNext = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  always_comb begin
    cnt       = int'(termCount);
    anchorI   = (cnt == 0) ? 0 : int'(lfsrNext[7:0]) % cnt;
    ruleStart = int'(lfsrNext[11:8]) % 3;
    aI        = int'(termA[anchorI]);
    bI        = int'(termB[anchorI]);
    splitHit  = 1'b0;
    splitRule = 0;
    mergeHit  = 1'b0;
    mergeRule = 0;
    partnerI  = 0;
    rr        = 0;
    for (int k = 0; k < 3; k++) begin
      rr = (ruleStart + k) % 3;
      if (!splitHit && splitFits(rr, aI, bI)) begin
        splitHit  = 1'b1;
        splitRule = rr;
      end
    end
    for (int k = 0; k < 3; k++) begin
      rr = (ruleStart + k) % 3;
      for (int j = 0; j < N; j++) begin
        if (!mergeHit && j < cnt && j != anchorI && termSign[j] == termSign[anchorI] &&
            mergeFits(rr, aI, bI, int'(termA[j]), int'(termB[j]))) begin
          mergeHit  = 1'b1;
          mergeRule = rr;
          partnerI  = j;
        end
      end
    end
  end

  assign doSplit = opGo && !opMode && (cnt > 0) && (cnt < N) && splitHit;
  assign doMerge = opGo && opMode && (cnt >= 2) && mergeHit;

  always_comb begin
    strobe.load    = loadReq;
    strobe.split   = doSplit;
    strobe.merge   = doMerge;
    strobe.rule    = rule_e'(2'(doSplit ? splitRule : mergeRule));
    strobe.anchor  = IDXW'(anchorI);
    strobe.partner = IDXW'(partnerI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr <= SEED;
      done <= 1'b0;
      noOp <= 1'b0;
    end else begin
      if (opGo) lfsr <= lfsrNext;
      done <= opGo;
      noOp <= opGo && !(doSplit || doMerge);
    end
  end

  // R4
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n) lfsr != 16'h0);
  // R9
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) opGo |=> done);
  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !opGo |=> !done);
  // R7
  noop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) noOp |-> done);
  // R7
  noop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && noOp) |-> $stable(termCount));
endmodule

// File: rtl/dbr_datapath.sv
module dbr_datapath
  import dbr_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 4,
  parameter int BW = 3,
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  strobe_t       strobe,
  input  logic          loadSign,
  input  logic [AW-1:0] loadA,
  input  logic [BW-1:0] loadB,
  output logic          termSign [N],
  output logic [AW-1:0] termA    [N],
  output logic [BW-1:0] termB    [N],
  output logic [CW-1:0] termCount
);
  logic          nSign [N], tSign [N];
  logic [AW-1:0] nA    [N], tA    [N];
  logic [BW-1:0] nB    [N], tB    [N];
  logic [CW-1:0] nCount;
  int anc, par, cntI, aI, bI, loA, loB, hiA, hiB;

  always_comb begin
    nSign  = termSign;
    nA     = termA;
    nB     = termB;
    nCount = termCount;
    tSign  = termSign;
    tA     = termA;
    tB     = termB;
    anc    = int'(strobe.anchor) % N;
    par    = int'(strobe.partner);
    cntI   = int'(termCount);
    aI     = int'(termA[anc]);
    bI     = int'(termB[anc]);
    loA = aI; loB = bI; hiA = aI; hiB = bI;
    if (strobe.load) begin
      for (int i = 0; i < N; i++) begin
        nSign[i] = 1'b0;
        nA[i]    = '0;
        nB[i]    = '0;
      end
      nSign[0] = loadSign;
      nA[0]    = loadA;
      nB[0]    = loadB;
      nCount   = CW'(1);
    end else if (strobe.split) begin
      case (strobe.rule)
        RULE_THREE: begin loA = aI;     loB = bI - 1; hiA = aI + 1; hiB = bI - 1; end
        RULE_FOUR:  begin loA = aI - 2; loB = bI;     hiA = aI - 2; hiB = bI + 1; end
        default:    begin loA = aI;     loB = bI - 2; hiA = aI + 3; hiB = bI - 2; end
      endcase
      nA[anc] = AW'(loA);
      nB[anc] = BW'(loB);
      if (cntI < N) begin
        nSign[cntI % N] = termSign[anc];
        nA[cntI % N]    = AW'(hiA);
        nB[cntI % N]    = BW'(hiB);
      end
      nCount = termCount + CW'(1);
    end else if (strobe.merge) begin
      case (strobe.rule)
        RULE_THREE: begin loA = aI;     loB = bI + 1; end
        RULE_FOUR:  begin loA = aI + 2; loB = bI;     end
        default:    begin loA = aI;     loB = bI + 2; end
      endcase
      tA[anc] = AW'(loA);
      tB[anc] = BW'(loB);
      for (int i = 0; i < N; i++) begin
        if (i < par) begin
          nSign[i] = tSign[i];
          nA[i]    = tA[i];
          nB[i]    = tB[i];
        end else if (i < N - 1) begin
          nSign[i] = tSign[(i + 1) % N];
          nA[i]    = tA[(i + 1) % N];
          nB[i]    = tB[(i + 1) % N];
        end else begin
          nSign[i] = 1'b0;
          nA[i]    = '0;
          nB[i]    = '0;
        end
      end
      nCount = termCount - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        termSign[i] <= 1'b0;
        termA[i]    <= '0;
        termB[i]    <= '0;
      end
      termCount <= '0;
    end else begin
      termSign  <= nSign;
      termA     <= nA;
      termB     <= nB;
      termCount <= nCount;
    end
  end

  // R5
  split_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.split && !strobe.load) |=> termCount == $past(termCount) + CW'(1));
  // R6
  merge_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.merge && !strobe.load) |=> termCount == $past(termCount) - CW'(1));
  // R2
  load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> termCount == CW'(1));
  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(termCount) <= N);

  for (genvar g = 0; g < N; g++) begin : g_idle
    // R10
    idle_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (CW'(g) >= termCount) |-> (!termSign[g] && termA[g] == '0 && termB[g] == '0));
  end
endmodule

// File: rtl/dbr_recoder.sv
module dbr_recoder
  import dbr_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 4,
  parameter int BW = 3,
  parameter int CW = $clog2(N + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            loadReq,
  input  logic            loadSign,
  input  logic [AW-1:0]   loadA,
  input  logic [BW-1:0]   loadB,
  input  logic            opReq,
  input  logic            opMode,
  output logic [N-1:0]    termSignVec,
  output logic [N*AW-1:0] termAVec,
  output logic [N*BW-1:0] termBVec,
  output logic [CW-1:0]   termCount,
  output logic            done,
  output logic            noOp
);
  strobe_t       strobe;
  logic          termSign [N];
  logic [AW-1:0] termA    [N];
  logic [BW-1:0] termB    [N];

  dbr_ctrl #(.N(N), .AW(AW), .BW(BW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .loadReq(loadReq), .opReq(opReq), .opMode(opMode),
    .termSign(termSign), .termA(termA), .termB(termB), .termCount(termCount),
    .strobe(strobe), .done(done), .noOp(noOp)
  );

  dbr_datapath #(.N(N), .AW(AW), .BW(BW), .CW(CW)) u_data (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .loadSign(loadSign), .loadA(loadA),
    .loadB(loadB), .termSign(termSign), .termA(termA), .termB(termB), .termCount(termCount)
  );

  for (genvar g = 0; g < N; g++) begin : g_flat
    assign termSignVec[g]       = termSign[g];
    assign termAVec[g*AW +: AW] = termA[g];
    assign termBVec[g*BW +: BW] = termB[g];
  end
endmodule

// File: tb/test_dbr_recoder.sv
module test_dbr_recoder;
  localparam int N  = 8;
  localparam int AW = 4;
  localparam int BW = 3;
  localparam int CW = $clog2(N + 1);
  localparam int CLK_PERIOD = 10;
  localparam int MAXA = (1 << AW) - 1;
  localparam int MAXB = (1 << BW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic loadReq = 1'b0, loadSign = 1'b0, opReq = 1'b0, opMode = 1'b0;
  logic [AW-1:0] loadA = '0;
  logic [BW-1:0] loadB = '0;
  logic [N-1:0] termSignVec;
  logic [N*AW-1:0] termAVec;
  logic [N*BW-1:0] termBVec;
  logic [CW-1:0] termCount;
  logic done, noOp;

  dbr_recoder #(.N(N), .AW(AW), .BW(BW)) i_dbr_recoder (
    .clk(clk), .rst_n(rst_n), .loadReq(loadReq), .loadSign(loadSign), .loadA(loadA),
    .loadB(loadB), .opReq(opReq), .opMode(opMode), .termSignVec(termSignVec),
    .termAVec(termAVec), .termBVec(termBVec), .termCount(termCount), .done(done), .noOp(noOp)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int ms[N], ma[N], mb[N];
  int mcount = 0;
  logic [15:0] mlfsr = 16'hACE1;
  bit mdone = 0, mnoop = 0;
  longint mval = 0;
  int checks = 0, fails = 0;
  string curTag = "R1";

  function automatic longint termVal(int s, int a, int b);
    longint v = 1;
    repeat (a) v = v * 2;
    repeat (b) v = v * 3;
    return s ? -v : v;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    longint dutVal = 0;
    check("R9 done", longint'(done), longint'(mdone));
    check("R7 noOp", longint'(noOp), longint'(mnoop));
    check({curTag, " count"}, longint'(termCount), longint'(mcount));
    check("R10 count bound", longint'(int'(termCount) <= N), 1);
    for (int i = 0; i < N; i++) begin
      longint act = {termSignVec[i], termAVec[i*AW +: AW], termBVec[i*BW +: BW]};
      longint exp = (ms[i] << (AW + BW)) | (ma[i] << BW) | mb[i];
      check((i >= mcount) ? "R10 idle slot" : {curTag, " slot"}, act, exp);
      if (i < int'(termCount))
        dutVal += termVal(int'(termSignVec[i]), int'(termAVec[i*AW +: AW]), int'(termBVec[i*BW +: BW]));
    end
    check("R3 value", dutVal, mval);
  endtask

  task automatic modelApply(input bit ld, input bit s, input int a, input int b,
                            input bit rq, input bit md);
    int anchor, rs, r;
    bit applied = 0;
    mdone = 0;
    mnoop = 0;
    if (ld) begin
      for (int i = 0; i < N; i++) begin ms[i] = 0; ma[i] = 0; mb[i] = 0; end
      ms[0] = s; ma[0] = a; mb[0] = b; mcount = 1;
      mval = termVal(s, a, b);
      return;
    end
    if (!rq) return;
    mlfsr = {mlfsr[14:0], mlfsr[15] ^ mlfsr[13] ^ mlfsr[12] ^ mlfsr[10]};
    mdone = 1;
    anchor = (mcount == 0) ? 0 : int'(mlfsr[7:0]) % mcount;
    rs = int'(mlfsr[11:8]) % 3;
    if (!md) begin
      if (mcount > 0 && mcount < N) begin
        for (int k = 0; k < 3; k++) begin
          int x = ma[anchor], y = mb[anchor];
          r = (rs + k) % 3;
          if (applied) continue;
          if (r == 0 && y >= 1 && x + 1 <= MAXA) begin
            mb[anchor] = y - 1; ms[mcount] = ms[anchor]; ma[mcount] = x + 1; mb[mcount] = y - 1;
            applied = 1;
          end else if (r == 1 && x >= 2 && y + 1 <= MAXB) begin
            ma[anchor] = x - 2; ms[mcount] = ms[anchor]; ma[mcount] = x - 2; mb[mcount] = y + 1;
            applied = 1;
          end else if (r == 2 && y >= 2 && x + 3 <= MAXA) begin
            mb[anchor] = y - 2; ms[mcount] = ms[anchor]; ma[mcount] = x + 3; mb[mcount] = y - 2;
            applied = 1;
          end
        end
        if (applied) mcount++;
      end
    end else if (mcount >= 2) begin
      int partner = -1;
      int x = ma[anchor], y = mb[anchor];
      for (int k = 0; k < 3; k++) begin
        r = (rs + k) % 3;
        for (int j = 0; j < mcount; j++) begin
          bit hit;
          if (applied || j == anchor || ms[j] != ms[anchor]) continue;
          hit = (r == 0) ? (ma[j] == x + 1 && mb[j] == y && y + 1 <= MAXB) :
                (r == 1) ? (ma[j] == x && mb[j] == y + 1 && x + 2 <= MAXA) :
                           (ma[j] == x + 3 && mb[j] == y && y + 2 <= MAXB);
          if (hit) begin
            applied = 1;
            partner = j;
            if (r == 0) mb[anchor] = y + 1;
            else if (r == 1) ma[anchor] = x + 2;
            else mb[anchor] = y + 2;
          end
        end
      end
      if (applied) begin
        for (int i = partner; i < N - 1; i++) begin
          ms[i] = ms[i+1]; ma[i] = ma[i+1]; mb[i] = mb[i+1];
        end
        ms[N-1] = 0; ma[N-1] = 0; mb[N-1] = 0;
        mcount--;
      end
    end
    mnoop = !applied;
  endtask

  task automatic step(input bit ld, input bit s, input int a, input int b,
                      input bit rq, input bit md, input string tag);
    @(negedge clk);
    compareAll();
    loadReq = ld; loadSign = s; loadA = AW'(a); loadB = BW'(b);
    opReq = rq; opMode = md;
    modelApply(ld, s, a, b, rq, md);
    curTag = tag;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin ms[i] = 0; ma[i] = 0; mb[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state compared on first step
    step(0, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 5, 0, 0, "R2");          // load +3^5
    step(1, 1, 2, 1, 1, 0, "R2");          // R2: load wins over request
    step(1, 0, 1, 6, 0, 0, "R2");          // load +2^1*3^6
    for (int i = 0; i < 12; i++) step(0, 0, 0, 0, 1, 0, "R5");   // fill, then full no-op
    for (int i = 0; i < 12; i++) step(0, 0, 0, 0, 1, 1, "R6");
    step(1, 0, MAXA, MAXB, 0, 0, "R2");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, "R8");    // nothing fits
    step(0, 0, 0, 0, 1, 1, "R7");          // reduce with one term
    step(1, 1, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 1, 0, "R7");          // -1 cannot split
    step(0, 0, 0, 0, 0, 0, "R9");          // done must drop
    step(1, 0, 3, 4, 0, 0, "R2");
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom % 100);
      if (r < 5)
        step(1, 1'($urandom % 2), int'($urandom % (MAXA + 1)), int'($urandom % (MAXB + 1)), 0, 0, "R2");
      else if (r < 90)
        step(0, 0, 0, 0, 1, (($urandom % 100) < 45), "R4");
      else
        step(0, 0, 0, 0, 0, 0, "R9");
    end
    @(negedge clk);
    compareAll();
    summary();
    $finish;
  end
endmodule